// File: doc/BRIEF.md
# Auto-Incrementing Buffer Pointer Register

This block holds the 16-bit control word that steers every data-port beat into the packet buffer memory. A single register combines an area select (receive or transmit), an auto-increment enable, a direction bit, a live read-only flag showing whether posted write data is still waiting, and an 11-bit byte pointer. Each beat on the data port is either a buffer read, issued straight to the buffer at the current pointer, or a buffer write, posted into a small write-data FIFO that later drains into the buffer. Which of the two it is depends on the direction bit.

With auto-increment enabled, the pointer steps by one doubleword after each accepted beat, so software can stream a packet without touching the register. With it disabled, every beat uses the same address, and software reloads a doubleword-aligned pointer between accesses. Buffer addresses always have their two lowest bits cleared, because every transfer is 32 bits wide. The register cannot be rewritten while posted writes remain in the FIFO, so queued data always lands at the addresses it was posted for.

Top module: `bufPtrReg`

## Requirements
- R1: After reset, every register bit reads 0, the FIFO is empty and no buffer read or write request is active.
- R2: The read-back word has this layout: bit 15 is the area select, bit 14 is auto-increment, bit 13 is the direction, bit 12 is reserved and always reads 0 whatever was written, bit 11 is the not-empty flag, which writes do not change, and bits 10..0 are the pointer. An accepted register write is visible on the next cycle.
- R3: A read beat presents the current area select on bufArea. A posted write keeps the area select that was in force when it was pushed, and presents it on bufWrArea when it drains.
- R4: With auto-increment set to 1, each accepted beat advances the pointer by 4, modulo 2048, in the following cycle.
- R5: With auto-increment set to 0, accepted beats leave the pointer unchanged.
- R6: Every buffer address equals the pointer with its two lowest bits forced to 0, while the read-back value keeps the bits as written.
- R7: With direction 1, a beat raises bufRdEn in the same cycle and pushes nothing into the FIFO. With direction 0, a beat is pushed into the FIFO together with its address and does not raise bufRdEn.
- R8: The not-empty flag reads 1 from the cycle after a push until the cycle after the last entry is popped.
- R9: The FIFO holds 3 doublewords (12 bytes) and drains in order. The head entry is presented with bufWrEn and is removed when bufWrAck is high. In write direction with the FIFO full, dataRdy is 0, and a beat is ignored: nothing is pushed and the pointer does not advance.
- R10: A register write is stalled, with regWrRdy at 0 and no field changing, while the FIFO is not empty or while a write-direction beat is presented in the same cycle. A write that is held waiting is taken once the FIFO has drained.
- R11: When a register write and a read beat are accepted in the same cycle, the beat uses the old pointer and the new value is loaded, without the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write request |
| regWrData | input | 16 | Register write value |
| regWrRdy | output | 1 | Register write accepted this cycle |
| regRdData | output | 16 | Register read-back |
| dataStb | input | 1 | Data-port beat |
| dataWrData | input | 32 | Beat write data |
| dataRdy | output | 1 | Beat accepted this cycle |
| bufRdEn | output | 1 | Buffer read request |
| bufRdAddr | output | 11 | Buffer read byte address |
| bufArea | output | 1 | Area of the read request (1 = receive) |
| bufWrEn | output | 1 | FIFO head valid, buffer write request |
| bufWrAddr | output | 11 | Buffer write byte address |
| bufWrData | output | 32 | Buffer write data |
| bufWrArea | output | 1 | Area of the write (1 = receive) |
| bufWrAck | input | 1 | Buffer took the head entry |

## Verification
The bench builds the block with its default parameters: 32-bit beats, a 12-byte FIFO and the 16-bit register with its 11-bit pointer. With these values, three pushes fill the FIFO, so the full-refusal and stall cases are reached within a few cycles. A start pointer of 0x7F8 crosses the 2048-byte wrap inside one full FIFO, so the drained addresses show both the modulo step and the in-order drain. Unaligned pointer values bring out the split between the address with its low bits masked and the read-back value that keeps them.

// File: rtl/bufPtrPkg.sv
`timescale 1ns/1ps
package bufPtrPkg;
  localparam int REG_W = 16;
  localparam int PTR_W = REG_W - 5;
  localparam int BIT_RCV = REG_W - 1;
  localparam int BIT_AUTO = REG_W - 2;
  localparam int BIT_DIR = REG_W - 3;

  typedef struct packed {
    logic load;
    logic advance;
    logic push;
    logic pop;
    logic rdBeat;
  } ptrStrobes_t;
endpackage

// File: rtl/bufPtrCtrl.sv
`timescale 1ns/1ps
module bufPtrCtrl
  import bufPtrPkg::*;
(
  input  logic        regWrEn,
  input  logic        dataStb,
  input  logic        readDir,
  input  logic        autoInc,
  input  logic        fifoEmpty,
  input  logic        fifoFull,
  input  logic        bufWrAck,
  output ptrStrobes_t strobes,
  output logic        regWrRdy,
  output logic        dataRdy
);
  logic writeBeat;
  logic beatTaken;

  always_comb begin
    writeBeat = dataStb && !readDir;
    dataRdy = readDir || !fifoFull;
    beatTaken = dataStb && dataRdy;
    regWrRdy = fifoEmpty && !writeBeat;
    strobes.load = regWrEn && regWrRdy;
    strobes.advance = beatTaken && autoInc && !strobes.load;
    strobes.push = beatTaken && !readDir;
    strobes.pop = bufWrAck && !fifoEmpty;
    strobes.rdBeat = dataStb && readDir;
  end
endmodule

// File: rtl/bufPtrData.sv
`timescale 1ns/1ps
module bufPtrData
  import bufPtrPkg::*;
#(
  parameter int BEAT_BYTES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ptrStrobes_t      strobes,
  input  logic [REG_W-1:0] wrValue,
  input  logic             notEmpty,
  output logic             rcvSel,
  output logic             autoInc,
  output logic             readDir,
  output logic [PTR_W-1:0] ptrAddr,
  output logic [PTR_W-1:0] ptrRaw,
  output logic [REG_W-1:0] rdValue
);
  localparam int ALIGN_BITS = $clog2(BEAT_BYTES);

  logic [PTR_W-1:0] ptrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rcvSel <= 1'b0;
      autoInc <= 1'b0;
      readDir <= 1'b0;
      ptrQ <= '0;
    end else if (strobes.load) begin
      rcvSel <= wrValue[BIT_RCV];
      autoInc <= wrValue[BIT_AUTO];
      readDir <= wrValue[BIT_DIR];
      ptrQ <= wrValue[PTR_W-1:0];
    end else if (strobes.advance) begin
      ptrQ <= ptrQ + PTR_W'(BEAT_BYTES);
    end
  end

  always_comb begin
    ptrRaw = ptrQ;
    ptrAddr = {ptrQ[PTR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    rdValue = {rcvSel, autoInc, readDir, 1'b0, notEmpty, ptrQ};
  end
endmodule

// File: rtl/bufPtrFifo.sv
`timescale 1ns/1ps
module bufPtrFifo
  import bufPtrPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FIFO_BYTES = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptrStrobes_t       strobes,
  input  logic              inArea,
  input  logic [PTR_W-1:0]  inAddr,
  input  logic [DATA_W-1:0] inData,
  output logic              empty,
  output logic              full,
  output logic              outArea,
  output logic [PTR_W-1:0]  outAddr,
  output logic [DATA_W-1:0] outData
);
  localparam int DEPTH = FIFO_BYTES / (DATA_W / 8);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = 1 + PTR_W + DATA_W;

  logic [EW-1:0] store [DEPTH];
  logic [IW-1:0] headIdx;
  logic [IW-1:0] tailIdx;
  logic [CW-1:0] count;

  function automatic logic [IW-1:0] nextIdx(input logic [IW-1:0] idx);
    return (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headIdx <= '0;
      tailIdx <= '0;
      count <= '0;
    end else begin
      if (strobes.push) tailIdx <= nextIdx(tailIdx);
      if (strobes.pop) headIdx <= nextIdx(headIdx);
      if (strobes.push && !strobes.pop) count <= count + 1'b1;
      else if (strobes.pop && !strobes.push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.push) store[tailIdx] <= {inArea, inAddr, inData};
  end

  always_comb begin
    empty = (count == '0);
    full = (count == CW'(DEPTH));
    {outArea, outAddr, outData} = store[headIdx];
  end
endmodule

// File: rtl/bufPtrReg.sv
`timescale 1ns/1ps
module bufPtrReg
  import bufPtrPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FIFO_BYTES = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic              regWrRdy,
  output logic [REG_W-1:0]  regRdData,
  input  logic              dataStb,
  input  logic [DATA_W-1:0] dataWrData,
  output logic              dataRdy,
  output logic              bufRdEn,
  output logic [PTR_W-1:0]  bufRdAddr,
  output logic              bufArea,
  output logic              bufWrEn,
  output logic [PTR_W-1:0]  bufWrAddr,
  output logic [DATA_W-1:0] bufWrData,
  output logic              bufWrArea,
  input  logic              bufWrAck
);
  ptrStrobes_t strobes;
  logic rcvSel, autoInc, readDir;
  logic fifoEmpty, fifoFull;
  logic [PTR_W-1:0] ptrAddr;
  logic [PTR_W-1:0] ptrRaw;

  bufPtrCtrl uCtrl (
    .regWrEn(regWrEn), .dataStb(dataStb), .readDir(readDir), .autoInc(autoInc),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .bufWrAck(bufWrAck),
    .strobes(strobes), .regWrRdy(regWrRdy), .dataRdy(dataRdy)
  );

  bufPtrData #(.BEAT_BYTES(DATA_W / 8)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrValue(regWrData),
    .notEmpty(!fifoEmpty), .rcvSel(rcvSel), .autoInc(autoInc), .readDir(readDir),
    .ptrAddr(ptrAddr), .ptrRaw(ptrRaw), .rdValue(regRdData)
  );

  bufPtrFifo #(.DATA_W(DATA_W), .FIFO_BYTES(FIFO_BYTES)) uFifo (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inArea(rcvSel), .inAddr(ptrAddr),
    .inData(dataWrData), .empty(fifoEmpty), .full(fifoFull), .outArea(bufWrArea),
    .outAddr(bufWrAddr), .outData(bufWrData)
  );

  always_comb begin
    bufRdEn = strobes.rdBeat;
    bufRdAddr = ptrAddr;
    bufArea = rcvSel;
    bufWrEn = !fifoEmpty;
  end
endmodule

// File: rtl/bufPtrChk.sv
`timescale 1ns/1ps
module bufPtrChk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic        regWrRdy,
  input logic [15:0] regRdData,
  input logic        dataStb,
  input logic        dataRdy,
  input logic        bufRdEn,
  input logic        bufArea,
  input logic        bufWrEn
);
  a_r4_advance: assert property (@(posedge clk) disable iff (!rstN)
    (dataStb && dataRdy && regRdData[14] && !(regWrEn && regWrRdy))
      |=> regRdData[10:0] == $past(regRdData[10:0]) + 11'd4);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dataStb && dataRdy && !regRdData[14] && !regWrEn) |=> $stable(regRdData[10:0]));

  a_r8_not_empty: assert property (@(posedge clk) disable iff (!rstN)
    (dataStb && dataRdy && !regRdData[13]) |=> regRdData[11]);

  a_r10_stall: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regWrRdy) |=> $stable(regRdData[15:13]));

  a_r9_full_pending: assert property (@(posedge clk) disable iff (!rstN)
    !dataRdy |-> bufWrEn);

  a_r3_area: assert property (@(posedge clk) disable iff (!rstN)
    bufRdEn |-> bufArea == regRdData[15]);
endmodule

bind bufPtrReg bufPtrChk uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrRdy(regWrRdy),
  .regRdData(regRdData), .dataStb(dataStb), .dataRdy(dataRdy),
  .bufRdEn(bufRdEn), .bufArea(bufArea), .bufWrEn(bufWrEn)
);

// File: tb/tb_bufPtrReg.sv
`timescale 1ns/1ps
module tb_bufPtrReg;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic regWrRdy;
  logic [15:0] regRdData;
  logic dataStb = 1'b0;
  logic [31:0] dataWrData = '0;
  logic dataRdy, bufRdEn, bufArea, bufWrEn, bufWrArea;
  logic [10:0] bufRdAddr, bufWrAddr;
  logic [31:0] bufWrData;
  logic bufWrAck = 1'b0;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bufPtrReg dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regWrRdy(regWrRdy), .regRdData(regRdData), .dataStb(dataStb),
    .dataWrData(dataWrData), .dataRdy(dataRdy), .bufRdEn(bufRdEn),
    .bufRdAddr(bufRdAddr), .bufArea(bufArea), .bufWrEn(bufWrEn),
    .bufWrAddr(bufWrAddr), .bufWrData(bufWrData), .bufWrArea(bufWrArea),
    .bufWrAck(bufWrAck)
  );

  // write value, expected read-back (R2 layout)
  localparam logic [31:0] VEC [7] = '{
    {16'h0000, 16'h0000}, {16'hFFFF, 16'hE7FF}, {16'h1800, 16'h0000},
    {16'h8123, 16'h8123}, {16'h4555, 16'h4555}, {16'hA7FF, 16'hA7FF},
    {16'h0000, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [15:0] v);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic beat(input logic [31:0] d);
    @(negedge clk);
    dataStb = 1'b1;
    dataWrData = d;
    #1;
  endtask

  task automatic endBeat();
    @(negedge clk);
    dataStb = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #100000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset readback", regRdData, 16'h0000);
    chk("R1 reset no write req", bufWrEn, 1'b0);
    chk("R1 reset no read req", bufRdEn, 1'b0);

    foreach (VEC[i]) begin
      regWrite(VEC[i][31:16]);
      chk($sformatf("R2 readback vec %0d", i), regRdData, VEC[i][15:0]);
    end

    // R4 wrap / R9 fill and drain order
    regWrite(16'h47F8);
    chk("R2 load 47F8", regRdData, 16'h47F8);
    for (int k = 0; k < 3; k++) begin
      beat(32'hA000_0000 + k);
      chk("R9 ready while not full", dataRdy, 1'b1);
      chk("R7 write beat no read req", bufRdEn, 1'b0);
      endBeat();
      chk("R8 not empty after push", regRdData[11], 1'b1);
    end
    chk("R4 wrap after 3 beats", regRdData, 16'h4804);
    beat(32'hDEAD_BEEF);
    chk("R9 full refuses", dataRdy, 1'b0);
    endBeat();
    chk("R9 ignored beat no advance", regRdData, 16'h4804);

    // R10 stall while FIFO holds data, then drain in order
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = 16'h2105;
    #1;
    chk("R10 stalled ready", regWrRdy, 1'b0);
    @(negedge clk);
    chk("R10 no change while stalled", regRdData, 16'h4804);
    bufWrAck = 1'b1;
    chk("R9 head addr 0", bufWrAddr, 11'h7F8);
    chk("R9 head data 0", bufWrData, 32'hA000_0000);
    @(negedge clk);
    chk("R9 head addr 1", bufWrAddr, 11'h7FC);
    chk("R9 head data 1", bufWrData, 32'hA000_0001);
    @(negedge clk);
    chk("R4 R6 head addr 2 wrapped", bufWrAddr, 11'h000);
    chk("R9 head data 2", bufWrData, 32'hA000_0002);
    chk("R3 write area transmit", bufWrArea, 1'b0);
    @(negedge clk);
    chk("R8 cleared after drain", regRdData, 16'h4004);
    chk("R10 ready after drain", regWrRdy, 1'b1);
    @(negedge clk);
    regWrEn = 1'b0;
    bufWrAck = 1'b0;
    chk("R10 held write taken", regRdData, 16'h2105);

    // R5 hold, R6 alignment, R7 read direction
    for (int k = 0; k < 2; k++) begin
      beat(32'h0);
      chk("R7 read beat raises bufRdEn", bufRdEn, 1'b1);
      chk("R6 R5 aligned held address", bufRdAddr, 11'h104);
      endBeat();
    end
    chk("R5 pointer held, R7 nothing pushed", regRdData, 16'h2105);

    // R3 receive area, R4 read sequence
    regWrite(16'hE010);
    beat(32'h0);
    chk("R3 area receive", bufArea, 1'b1);
    chk("R4 first addr", bufRdAddr, 11'h010);
    endBeat();
    beat(32'h0);
    chk("R4 second addr", bufRdAddr, 11'h014);
    endBeat();
    chk("R4 after two beats", regRdData, 16'hE018);

    // R11 register write with read beat in same cycle
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = 16'hE100;
    dataStb = 1'b1;
    #1;
    chk("R11 beat uses old pointer", bufRdAddr, 11'h018);
    chk("R11 write accepted", regWrRdy, 1'b1);
    @(negedge clk);
    regWrEn = 1'b0;
    dataStb = 1'b0;
    chk("R11 load wins over increment", regRdData, 16'hE100);

    // R3 area captured per write entry
    regWrite(16'hC020);
    beat(32'h1234_5678);
    endBeat();
    regWrite(16'h0000);
    chk("R10 write during pending ignored", regRdData, 16'hC824);
    chk("R3 write area receive", bufWrArea, 1'b1);
    chk("R6 write entry addr", bufWrAddr, 11'h020);
    @(negedge clk);
    bufWrAck = 1'b1;
    @(negedge clk);
    bufWrAck = 1'b0;
    chk("R8 empty after single pop", regRdData[11], 1'b0);

    finish();
  end
endmodule